// File: doc/BRIEF.md
# Four-Requester Address Bus Arbiter

This block decides which of four masters may drive a processor-side address bus. The four requesters are the bridge's internal master, one external master and two CPUs. Every cycle it looks at the request lines and its configuration inputs, then registers a one-hot grant. The two masters that are not CPUs always sit above the CPU pair. Within the pair the order is either fixed or alternating. When nobody requests, the bus can be left granted to a CPU, following one of four parking modes.

For debug, the arbiter can serialize the bus pipeline. The owner reports that it has consumed its grant by pulsing `start_i` with the transfer type. If serializing is enabled for that type, no further grant is issued until `done_i` marks the end of that transfer's data phase. Each type can be serialized either always or only when the new transfer comes from a different master than the previous one.

Top module: `bus_arb4`

## Requirements
- R1: `gnt_o` is registered and has at most one bit set. Bit 0 is the internal master, bit 1 the external master, bit 2 CPU0 and bit 3 CPU1. The grant computed from the inputs of one cycle appears after the next rising edge, and during reset `gnt_o` is 0.
- R2: When not blocked by serializing, a request on bit 0 is granted whatever the other requests, CPU mode or parking mode are.
- R3: When bit 0 is idle and bit 1 requests, bit 1 wins over both CPUs.
- R4: With `cpu_rot_i` = 0, CPU0 wins when both CPUs request. A CPU requesting alone wins when no higher requester is active.
- R5: With `cpu_rot_i` = 1, a pointer decides between two requesting CPUs. After reset it favours CPU0. A `start_i` pulse while a CPU holds the grant moves it to favour the other CPU, and that change already applies to the grant computed in the same cycle.
- R6: With no requests, `park_mode_i` chooses the grant: 00 gives none, 01 gives CPU0, 10 gives CPU1, and 11 gives the CPU most recently granted (CPU0 after reset).
- R7: Parking never grants bit 0 or bit 1. With `park_mode_i` = 00 and no requests, `gnt_o` is 0.
- R8: `xfer_type_i` encodes bit 1 = burst and bit 0 = write, so 00 is a single read, 01 a single write, 10 a burst read and 11 a burst write. Bit t of `flat_en_i` enables serializing for type t. A `start_i` of an enabled type forces `gnt_o` to 0 from the next cycle through the cycle in which `done_i` is high. A grant may appear in the cycle after that.
- R9: When bit t of `flat_sw_i` is set, type t is serialized only if the master starting the transfer differs from the master of the previous `start_i`. The first start after reset counts as a switch.
- R10: A start that is not serialized does not stop granting, and `done_i` has no effect while no serialized transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request lines, same bit order as the grant |
| cpu_rot_i | input | 1 | 0 = fixed CPU order, 1 = alternating |
| park_mode_i | input | 2 | Parking mode selector |
| flat_en_i | input | 4 | Serializing enable per transfer type |
| flat_sw_i | input | 4 | Per type: serialize only on a change of master |
| start_i | input | 1 | Grant holder begins a transfer |
| xfer_type_i | input | 2 | Type of the transfer being started |
| done_i | input | 1 | Data phase of the pending transfer has finished |
| gnt_o | output | 4 | One-hot registered grant |

## Verification
The hardest situations to reach are the ones that depend on history: a change-of-master decision needs the identity of the previous starter, and last-CPU parking needs the previous CPU grant. The stimulus builds that history on purpose. It first grants and starts a transfer from one master, then starts the next transfer from another master, and then from the same master again, so the same type is seen once serialized and once passed through. The parking steps follow CPU grants whose order is known, so the remembered CPU can be predicted.

// File: rtl/arb4_pkg.sv
package arb4_pkg;
  localparam int unsigned NREQ  = 4;
  localparam int unsigned IDW   = $clog2(NREQ);
  localparam int unsigned TYW   = 2;
  localparam int unsigned NTYPE = 1 << TYW;

  typedef enum logic [IDW-1:0] {
    ID_BRG  = 2'd0,
    ID_EXT  = 2'd1,
    ID_CPU0 = 2'd2,
    ID_CPU1 = 2'd3
  } mst_e;

  typedef enum logic [1:0] {
    PARK_OFF  = 2'b00,
    PARK_C0   = 2'b01,
    PARK_C1   = 2'b10,
    PARK_LAST = 2'b11
  } park_e;

  function automatic logic [IDW-1:0] oh2id(logic [NREQ-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < NREQ; i++) if (v[i]) r = i[IDW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/arb4_prio.sv
module arb4_prio
  import arb4_pkg::*;
(
  input  logic [NREQ-1:0] req_i,
  input  logic            rot_en_i,
  input  logic            fav_c1_i,
  output logic [NREQ-1:0] win_o
);
  always_comb begin
    win_o = '0;
    if (req_i[ID_BRG])
      win_o[ID_BRG] = 1'b1;
    else if (req_i[ID_EXT])
      win_o[ID_EXT] = 1'b1;
    else if (req_i[ID_CPU0] && req_i[ID_CPU1]) begin
      if (rot_en_i && fav_c1_i) win_o[ID_CPU1] = 1'b1;
      else                      win_o[ID_CPU0] = 1'b1;
    end else if (req_i[ID_CPU0])
      win_o[ID_CPU0] = 1'b1;
    else if (req_i[ID_CPU1])
      win_o[ID_CPU1] = 1'b1;
  end
endmodule

// File: rtl/arb4_park.sv
module arb4_park
  import arb4_pkg::*;
(
  input  logic [1:0]      mode_i,
  input  logic            last_c1_i,
  output logic [NREQ-1:0] park_o
);
  park_e mode;
  assign mode = park_e'(mode_i);

  always_comb begin
    park_o = '0;
    unique case (mode)
      PARK_C0:   park_o[ID_CPU0] = 1'b1;
      PARK_C1:   park_o[ID_CPU1] = 1'b1;
      PARK_LAST: park_o[last_c1_i ? ID_CPU1 : ID_CPU0] = 1'b1;
      default:   park_o = '0;
    endcase
  end
endmodule

// File: rtl/arb4_flat.sv
module arb4_flat
  import arb4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [TYW-1:0]   type_i,
  input  logic             own_vld_i,
  input  logic [IDW-1:0]   own_id_i,
  input  logic [NTYPE-1:0] en_i,
  input  logic [NTYPE-1:0] sw_i,
  output logic             blk_o
);
  logic             hold_q;
  logic             last_vld_q;
  logic [IDW-1:0]   last_id_q;
  logic             switched;
  logic             take;
  logic [NTYPE-1:0] type_hit;
  logic             hit;
  logic             hold_set;

  assign take     = start_i && own_vld_i;
  assign switched = !last_vld_q || (own_id_i != last_id_q);

  for (genvar t = 0; t < NTYPE; t++) begin : g_type
    assign type_hit[t] = en_i[t] && (!sw_i[t] || switched);
  end

  assign hit      = take && type_hit[type_i];
  assign hold_set = hit && !done_i;
  assign blk_o    = hold_set || (hold_q && !done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      last_vld_q <= 1'b0;
      last_id_q  <= '0;
    end else begin
      if (hold_set)    hold_q <= 1'b1;
      else if (done_i) hold_q <= 1'b0;
      if (take) begin
        last_vld_q <= 1'b1;
        last_id_q  <= own_id_i;
      end
    end
  end
endmodule

// File: rtl/bus_arb4.sv
module bus_arb4
  import arb4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NREQ-1:0]  req_i,
  input  logic             cpu_rot_i,
  input  logic [1:0]       park_mode_i,
  input  logic [NTYPE-1:0] flat_en_i,
  input  logic [NTYPE-1:0] flat_sw_i,
  input  logic             start_i,
  input  logic [TYW-1:0]   xfer_type_i,
  input  logic             done_i,
  output logic [NREQ-1:0]  gnt_o
);
  logic [NREQ-1:0] gnt_q, gnt_d, win, park;
  logic            fav_c1_q, fav_c1_eff;
  logic            last_c1_q;
  logic            cpu_take;
  logic            blk;
  logic            own_vld;
  logic [IDW-1:0]  own_id;

  assign own_vld  = |gnt_q;
  assign own_id   = oh2id(gnt_q);
  assign cpu_take = start_i && (gnt_q[ID_CPU0] || gnt_q[ID_CPU1]);
  // consumed CPU grant hands preference to the other CPU at once
  assign fav_c1_eff = (cpu_take && cpu_rot_i) ? gnt_q[ID_CPU0] : fav_c1_q;

  arb4_prio u_prio (
    .req_i   (req_i),
    .rot_en_i(cpu_rot_i),
    .fav_c1_i(fav_c1_eff),
    .win_o   (win)
  );

  arb4_park u_park (
    .mode_i   (park_mode_i),
    .last_c1_i(last_c1_q),
    .park_o   (park)
  );

  arb4_flat u_flat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .done_i   (done_i),
    .type_i   (xfer_type_i),
    .own_vld_i(own_vld),
    .own_id_i (own_id),
    .en_i     (flat_en_i),
    .sw_i     (flat_sw_i),
    .blk_o    (blk)
  );

  always_comb begin
    if (blk)         gnt_d = '0;
    else if (|req_i) gnt_d = win;
    else             gnt_d = park;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q     <= '0;
      fav_c1_q  <= 1'b0;
      last_c1_q <= 1'b0;
    end else begin
      gnt_q    <= gnt_d;
      fav_c1_q <= fav_c1_eff;
      if (gnt_d[ID_CPU0])      last_c1_q <= 1'b0;
      else if (gnt_d[ID_CPU1]) last_c1_q <= 1'b1;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb4_chk.sv
module arb4_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] req_i,
  input logic       cpu_rot_i,
  input logic [1:0] park_mode_i,
  input logic       blk,
  input logic [3:0] gnt_o
);
  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_brg_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[0] && !blk) |=> gnt_o[0]);

  p_ext_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i[0] && req_i[1] && !blk) |=> gnt_o[1]);

  p_fixed_c0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_rot_i && req_i == 4'b1100 && !blk) |=> gnt_o == 4'b0100);

  p_nopark_brg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i[0] |=> !gnt_o[0]);

  p_nopark_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i[1] |=> !gnt_o[1]);

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 4'b0000 && park_mode_i == 2'b00) |=> gnt_o == 4'b0000);

  p_flat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk |=> gnt_o == 4'b0000);
endmodule

bind bus_arb4 arb4_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .cpu_rot_i  (cpu_rot_i),
  .park_mode_i(park_mode_i),
  .blk        (blk),
  .gnt_o      (gnt_o)
);

// File: tb/sim_bus_arb4.sv
module sim_bus_arb4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       rot = 1'b0;
  logic [1:0] park = 2'b00;
  logic [3:0] fen = '0;
  logic [3:0] fsw = '0;
  logic       st = 1'b0;
  logic [1:0] ty = '0;
  logic       dn = 1'b0;
  logic [3:0] gnt;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    ended = 1'b0;

  always #4 clk = ~clk;

  bus_arb4 u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .cpu_rot_i  (rot),
    .park_mode_i(park),
    .flat_en_i  (fen),
    .flat_sw_i  (fsw),
    .start_i    (st),
    .xfer_type_i(ty),
    .done_i     (dn),
    .gnt_o      (gnt)
  );

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and queues the grant expected after the edge
  task automatic step(input logic r_rot, input logic [1:0] r_park,
                      input logic [3:0] r_fen, input logic [3:0] r_fsw,
                      input logic [3:0] r_req, input logic r_st,
                      input logic [1:0] r_ty, input logic r_dn,
                      input logic [3:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rot = r_rot; park = r_park; fen = r_fen; fsw = r_fsw;
    req = r_req; st = r_st; ty = r_ty; dn = r_dn;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (gnt !== it.exp) begin
          n_fail++;
          $display("FAIL %s: gnt actual %b expected %b", it.tag, gnt, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (gnt !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset: gnt actual %b expected 0000", gnt);
    end
    rst_n = 1'b1;
    // priority, fixed CPU order
    step(0, 2'b00, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0000, "R7 idle no park");
    step(0, 2'b00, 4'h0, 4'h0, 4'b1111, 0, 2'b00, 0, 4'b0001, "R2 all request");
    step(0, 2'b00, 4'h0, 4'h0, 4'b1110, 0, 2'b00, 0, 4'b0010, "R3 ext over cpus");
    step(0, 2'b00, 4'h0, 4'h0, 4'b1100, 0, 2'b00, 0, 4'b0100, "R4 fixed cpu0 wins");
    step(0, 2'b00, 4'h0, 4'h0, 4'b1000, 0, 2'b00, 0, 4'b1000, "R4 cpu1 alone");
    // rotating
    step(1, 2'b00, 4'h0, 4'h0, 4'b1101, 0, 2'b00, 0, 4'b0001, "R2 rotating mode");
    step(1, 2'b00, 4'h0, 4'h0, 4'b1100, 0, 2'b00, 0, 4'b0100, "R5 reset favours cpu0");
    step(1, 2'b00, 4'h0, 4'h0, 4'b1100, 1, 2'b00, 0, 4'b1000, "R5 rotate to cpu1");
    step(1, 2'b00, 4'h0, 4'h0, 4'b1100, 1, 2'b00, 0, 4'b0100, "R5 rotate back to cpu0");
    step(1, 2'b00, 4'h0, 4'h0, 4'b1100, 0, 2'b00, 0, 4'b0100, "R5 no consume keeps");
    // parking
    step(0, 2'b00, 4'h0, 4'h0, 4'b1000, 0, 2'b00, 0, 4'b1000, "R4 cpu1 alone again");
    step(0, 2'b11, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b1000, "R6 park last cpu1");
    step(0, 2'b01, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0100, "R6 park cpu0");
    step(0, 2'b10, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b1000, "R6 park cpu1");
    step(0, 2'b01, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0100, "R6 park cpu0 again");
    step(0, 2'b11, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0100, "R6 park last cpu0");
    step(0, 2'b11, 4'h0, 4'h0, 4'b0010, 0, 2'b00, 0, 4'b0010, "R3 ext with parking");
    step(0, 2'b11, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0100, "R7 park skips ext");
    step(0, 2'b00, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0000, "R7 no park idle");
    // unconditional serializing of single reads
    step(0, 2'b00, 4'h1, 4'h0, 4'b0010, 0, 2'b00, 0, 4'b0010, "R3 ext grant");
    step(0, 2'b00, 4'h1, 4'h0, 4'b0010, 1, 2'b00, 0, 4'b0000, "R8 single read held");
    step(0, 2'b00, 4'h1, 4'h0, 4'b0011, 0, 2'b00, 0, 4'b0000, "R8 hold over bridge req");
    step(0, 2'b00, 4'h1, 4'h0, 4'b0011, 0, 2'b00, 1, 4'b0001, "R8 release after done");
    step(0, 2'b00, 4'h1, 4'h0, 4'b0010, 1, 2'b01, 0, 4'b0010, "R10 single write not held");
    step(0, 2'b00, 4'h1, 4'h0, 4'b0010, 0, 2'b00, 1, 4'b0010, "R10 done ignored");
    // switch-qualified burst writes
    step(0, 2'b00, 4'h8, 4'h8, 4'b0010, 1, 2'b11, 0, 4'b0000, "R9 switch held");
    step(0, 2'b00, 4'h8, 4'h8, 4'b0010, 0, 2'b00, 1, 4'b0010, "R8 done releases");
    step(0, 2'b00, 4'h8, 4'h8, 4'b0010, 1, 2'b11, 0, 4'b0010, "R9 same master passes");
    step(0, 2'b00, 4'h8, 4'h0, 4'b0010, 1, 2'b11, 0, 4'b0000, "R9 unconditional held");
    step(0, 2'b00, 4'h8, 4'h0, 4'b0000, 0, 2'b00, 1, 4'b0000, "R7 idle after done");
    // burst read
    step(0, 2'b00, 4'h4, 4'h0, 4'b0100, 0, 2'b00, 0, 4'b0100, "R4 cpu0 grant");
    step(0, 2'b00, 4'h4, 4'h0, 4'b0100, 1, 2'b10, 0, 4'b0000, "R8 burst read held");
    step(0, 2'b00, 4'h4, 4'h0, 4'b0100, 0, 2'b00, 0, 4'b0000, "R8 still held");
    step(0, 2'b00, 4'h4, 4'h0, 4'b0100, 0, 2'b00, 1, 4'b0100, "R8 release cpu0");
    step(0, 2'b00, 4'h0, 4'h0, 4'b0000, 0, 2'b00, 0, 4'b0000, "R7 final idle");
    repeat (4) @(negedge clk);
    report();
  end
endmodule